// File: doc/BRIEF.md
# Interrupt Destination Bitmask Generator

This block turns one interrupt request into the set of processing units that should receive it. A request carries an 8-bit destination, a bit that chooses physical or logical addressing, a 2-bit shorthand, a 3-bit delivery mode and an 8-bit vector. Each of the N units is described by configuration inputs: an 8-bit identifier, an 8-bit logical destination and a 4-bit addressing-model field. The index of the sending unit is also an input, because some shorthands include or exclude the sender.

Every unit is compared against the destination in parallel. The shorthand then either keeps that match result or replaces it with a fixed pattern built from the sender index. For lowest-priority delivery, the result is cut down to one target. The mask, the vector and the delivery mode are registered together and announced by a one-cycle valid strobe. For startup delivery, the vector travels with the mask as the start vector for every selected unit. Transport of the interrupt and arbitration between units are handled elsewhere.

Top module: `irq_target_mask`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mask_valid`, `target_mask`, `out_vector` and `out_mode` are all cleared to zero at that edge.
- R2: A request sampled with `req_valid` high at an edge gives `mask_valid` high for exactly the following cycle. If no request is sampled, `mask_valid` is low and `target_mask`, `out_vector` and `out_mode` keep their last values.
- R3: Shorthand 1 selects only the unit whose index equals `self_idx`, whatever the destination.
- R4: Shorthand 2 selects every unit, the sender included.
- R5: Shorthand 3 selects every unit except the one whose index equals `self_idx`.
- R6: With shorthand 0 and `logical_mode` = 0 (physical):
  - a destination of 0xFF selects every unit;
  - any other destination selects each unit whose identifier equals it;
  - if no unit matches, the mask is all zero.
- R7: With shorthand 0 and `logical_mode` = 1, a unit whose model field is 0xF (flat) is selected when destination AND its logical destination is nonzero.
- R8: With shorthand 0 and `logical_mode` = 1, a unit whose model field is 0x0 (cluster) is selected when two conditions both hold:
  - the upper nibble of the destination equals the upper nibble of its logical destination;
  - the AND of the two lower nibbles is nonzero.
- R9: With shorthand 0 and `logical_mode` = 1, a unit whose model field is neither 0xF nor 0x0 is never selected.
- R10: Delivery mode 1 (lowest priority) keeps only the lowest-indexed selected unit (bit 0 is unit 0). An empty selection stays empty. This reduction applies after any shorthand.
- R11: Delivery mode 6 (startup) is not reduced: every selected unit stays in the mask. `out_vector` carries the request's vector as the start vector, and `out_mode` echoes the request's delivery mode for every delivery mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| dest | input | DEST_W | Destination field |
| logical_mode | input | 1 | 0 = physical addressing, 1 = logical addressing |
| shorthand | input | 2 | 0 = use destination, 1 = sender only, 2 = all, 3 = all but sender |
| dlv_mode | input | 3 | Delivery mode (1 = lowest priority, 6 = startup) |
| vector | input | VEC_W | Interrupt or start vector |
| self_idx | input | IDX_W | Index of the sending unit |
| unit_id | input | N_UNITS*DEST_W | Per-unit identifiers, unit i in slice i |
| unit_ldest | input | N_UNITS*DEST_W | Per-unit logical destinations, unit i in slice i |
| unit_model | input | N_UNITS*MODEL_W | Per-unit addressing model, unit i in slice i |
| mask_valid | output | 1 | One-cycle strobe marking a new mask |
| target_mask | output | N_UNITS | Selected units, bit i = unit i |
| out_vector | output | VEC_W | Vector registered with the mask |
| out_mode | output | 3 | Delivery mode registered with the mask |

## Verification
The embedded properties check, on every cycle, that the valid strobe follows each request by one cycle and that reset clears it. They also check that lowest-priority results never hold more than one unit, that the sender-only shorthand yields at most one unit, that the all-but-sender shorthand never includes the sender, and that a physical broadcast yields a full mask. Which particular unit is chosen can only be shown by the bench's scenarios, compared against its behavioural model. This covers identifier matches, flat and cluster logical matching, the exclusion of units with other model values, the lowest-index choice, and that startup masks stay whole.

// File: rtl/irq_tgt_pkg.sv
// Shared encodings for the interrupt destination bitmask generator.
// Assumes an 8-bit destination split into two nibbles for cluster matching.
package irq_tgt_pkg;

    typedef enum logic [1:0] {
        SH_DEST   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    localparam logic [2:0] DM_LOWEST  = 3'd1;
    localparam logic [2:0] DM_STARTUP = 3'd6;

    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;

endpackage

// File: rtl/unit_dest_match.sv
// Matches one unit's configuration against a request destination.
// Physical: all-ones destination or equal identifier.
// Logical: flat model ANDs the full field, cluster model compares the upper
// half and ANDs the lower half. Other model values never match.
// Assumes DEST_W is even; MODEL_W is at least 4.
module unit_dest_match
    import irq_tgt_pkg::*;
#(
    parameter int DEST_W  = 8,
    parameter int MODEL_W = 4
) (
    input  logic [DEST_W-1:0]  dest,
    input  logic               logical_mode,
    input  logic [DEST_W-1:0]  unit_id,
    input  logic [DEST_W-1:0]  unit_ldest,
    input  logic [MODEL_W-1:0] unit_model,
    output logic               hit
);
    localparam int HALF = DEST_W / 2;

    logic phys_hit;
    logic flat_hit;
    logic clus_hit;

    // Physical match: broadcast or exact identifier.
    always_comb begin
        phys_hit = (&dest) || (unit_id == dest);
    end

    // Logical matches for the two supported models.
    always_comb begin
        flat_hit = (unit_model == MODEL_W'(MODEL_FLAT)) && (|(dest & unit_ldest));
        clus_hit = (unit_model == MODEL_W'(MODEL_CLUSTER))
                && (dest[DEST_W-1:HALF] == unit_ldest[DEST_W-1:HALF])
                && (|(dest[HALF-1:0] & unit_ldest[HALF-1:0]));
    end

    // Select the result for the addressing mode.
    always_comb begin
        hit = logical_mode ? (flat_hit || clus_hit) : phys_hit;
    end

endmodule

// File: rtl/lowest_pick.sv
// Keeps only the lowest set bit of a vector; zero stays zero.
// Assumes bit 0 has the highest precedence.
module lowest_pick #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] in_vec,
    output logic [WIDTH-1:0] out_vec
);
    // Two's complement isolates the least significant one.
    always_comb begin
        out_vec = in_vec & (~in_vec + WIDTH'(1));
    end

endmodule

// File: rtl/shorthand_sel.sv
// Replaces the per-unit match vector according to the shorthand code.
// Assumes self_hot is one-hot or zero.
module shorthand_sel
    import irq_tgt_pkg::*;
#(
    parameter int N_UNITS = 8
) (
    input  logic [1:0]         shorthand,
    input  logic [N_UNITS-1:0] match_vec,
    input  logic [N_UNITS-1:0] self_hot,
    output logic [N_UNITS-1:0] sel_vec
);
    shorthand_e sh;

    // Decode the shorthand and choose the candidate set.
    always_comb begin
        sh = shorthand_e'(shorthand);
        unique case (sh)
            SH_DEST:   sel_vec = match_vec;
            SH_SELF:   sel_vec = self_hot;
            SH_ALL:    sel_vec = '1;
            SH_OTHERS: sel_vec = ~self_hot;
            default:   sel_vec = '0;
        endcase
    end

endmodule

// File: rtl/irq_target_mask.sv
// Interrupt destination bitmask generator, top level.
// Matches all units in parallel, applies the shorthand, reduces
// lowest-priority requests to one target and registers the result with a
// one-cycle valid strobe. Assumes N_UNITS >= 2 and a synchronous reset.
module irq_target_mask
    import irq_tgt_pkg::*;
#(
    parameter  int N_UNITS = 8,
    parameter  int DEST_W  = 8,
    parameter  int MODEL_W = 4,
    parameter  int VEC_W   = 8,
    localparam int IDX_W   = $clog2(N_UNITS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [DEST_W-1:0]            dest,
    input  logic                         logical_mode,
    input  logic [1:0]                   shorthand,
    input  logic [2:0]                   dlv_mode,
    input  logic [VEC_W-1:0]             vector,
    input  logic [IDX_W-1:0]             self_idx,
    input  logic [N_UNITS*DEST_W-1:0]    unit_id,
    input  logic [N_UNITS*DEST_W-1:0]    unit_ldest,
    input  logic [N_UNITS*MODEL_W-1:0]   unit_model,
    output logic                         mask_valid,
    output logic [N_UNITS-1:0]           target_mask,
    output logic [VEC_W-1:0]             out_vector,
    output logic [2:0]                   out_mode
);
    logic [N_UNITS-1:0] match_vec;
    logic [N_UNITS-1:0] self_hot;
    logic [N_UNITS-1:0] sel_vec;
    logic [N_UNITS-1:0] first_vec;
    logic [N_UNITS-1:0] next_mask;

    // One comparator and one sender decode per unit.
    for (genvar gi = 0; gi < N_UNITS; gi++) begin : g_unit
        unit_dest_match #(
            .DEST_W (DEST_W),
            .MODEL_W(MODEL_W)
        ) match_i (
            .dest        (dest),
            .logical_mode(logical_mode),
            .unit_id     (unit_id[gi*DEST_W +: DEST_W]),
            .unit_ldest  (unit_ldest[gi*DEST_W +: DEST_W]),
            .unit_model  (unit_model[gi*MODEL_W +: MODEL_W]),
            .hit         (match_vec[gi])
        );
        assign self_hot[gi] = (self_idx == IDX_W'(gi));
    end

    shorthand_sel #(
        .N_UNITS(N_UNITS)
    ) sh_i (
        .shorthand(shorthand),
        .match_vec(match_vec),
        .self_hot (self_hot),
        .sel_vec  (sel_vec)
    );

    lowest_pick #(
        .WIDTH(N_UNITS)
    ) pick_i (
        .in_vec (sel_vec),
        .out_vec(first_vec)
    );

    // Lowest-priority delivery keeps only the first target.
    always_comb begin
        next_mask = (dlv_mode == DM_LOWEST) ? first_vec : sel_vec;
    end

    // Register the result and raise valid for one cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_valid  <= 1'b0;
            target_mask <= '0;
            out_vector  <= '0;
            out_mode    <= '0;
        end else begin
            mask_valid <= req_valid;
            if (req_valid) begin
                target_mask <= next_mask;
                out_vector  <= vector;
                out_mode    <= dlv_mode;
            end
        end
    end

    // R1: reset leaves no strobe behind.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !mask_valid && (target_mask == '0));

    // R2: valid is the request delayed by one cycle.
    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> mask_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !mask_valid);

    // R3: sender-only shorthand gives at most one target.
    a_r3_self_only: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (shorthand == 2'd1) |=> $onehot0(target_mask));

    // R5: all-but-sender never includes the sender.
    a_r5_skip_sender: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (shorthand == 2'd3) |=> !target_mask[$past(self_idx)]);

    // R6: physical broadcast reaches every unit (unless reduced).
    a_r6_broadcast_all: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (shorthand == 2'd0) && !logical_mode && (&dest)
        && (dlv_mode != DM_LOWEST) |=> (&target_mask));

    // R10: lowest-priority output never names two units.
    a_r10_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        mask_valid && (out_mode == DM_LOWEST) |-> $onehot0(target_mask));

endmodule

// File: tb/irq_target_mask_tb_top.sv
// Bench for irq_target_mask: a behavioural reference model updated on every
// clock and compared a quarter period after each rising edge.
module irq_target_mask_tb_top;
    localparam int CLK_P   = 10;
    localparam int N       = 8;
    localparam int IDX_W   = 3;
    localparam int N_RAND  = 400;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [7:0]       dest = '0;
    logic             logical_mode = 1'b0;
    logic [1:0]       shorthand = '0;
    logic [2:0]       dlv_mode = '0;
    logic [7:0]       vector = '0;
    logic [IDX_W-1:0] self_idx = '0;
    logic [N*8-1:0]   unit_id;
    logic [N*8-1:0]   unit_ldest;
    logic [N*4-1:0]   unit_model;
    logic             mask_valid;
    logic [N-1:0]     target_mask;
    logic [7:0]       out_vector;
    logic [2:0]       out_mode;

    logic [7:0] cfg_id    [N] = '{8'h20, 8'h21, 8'h05, 8'h07, 8'h30, 8'h31, 8'h40, 8'h41};
    logic [7:0] cfg_ldest [N] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h31, 8'h32, 8'hFF, 8'hC0};
    logic [3:0] cfg_model [N] = '{4'hF, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h5, 4'hF};

    always_comb begin
        for (int i = 0; i < N; i++) begin
            unit_id[i*8 +: 8]    = cfg_id[i];
            unit_ldest[i*8 +: 8] = cfg_ldest[i];
            unit_model[i*4 +: 4] = cfg_model[i];
        end
    end

    irq_target_mask dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .dest        (dest),
        .logical_mode(logical_mode),
        .shorthand   (shorthand),
        .dlv_mode    (dlv_mode),
        .vector      (vector),
        .self_idx    (self_idx),
        .unit_id     (unit_id),
        .unit_ldest  (unit_ldest),
        .unit_model  (unit_model),
        .mask_valid  (mask_valid),
        .target_mask (target_mask),
        .out_vector  (out_vector),
        .out_mode    (out_mode)
    );

    always #(CLK_P/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_tag  = "R2";

    // Behavioural rule for one unit against a destination.
    function automatic bit unit_hit(int i, logic [7:0] d, logic lg);
        if (!lg) return (d == 8'hFF) || (cfg_id[i] == d);
        if (cfg_model[i] == 4'hF) return (d & cfg_ldest[i]) != 0;
        if (cfg_model[i] == 4'h0)
            return (d[7:4] == cfg_ldest[i][7:4]) && ((d[3:0] & cfg_ldest[i][3:0]) != 0);
        return 1'b0;
    endfunction

    function automatic logic [N-1:0] ref_mask(logic [7:0] d, logic lg, logic [1:0] sh,
                                              logic [2:0] md, int me);
        logic [N-1:0] m = '0;
        bit found = 1'b0;
        for (int i = 0; i < N; i++) begin
            case (sh)
                2'd0: m[i] = unit_hit(i, d, lg);
                2'd1: m[i] = (i == me);
                2'd2: m[i] = 1'b1;
                default: m[i] = (i != me);
            endcase
        end
        if (md == 3'd1) begin
            for (int i = 0; i < N; i++) begin
                if (m[i] && !found) found = 1'b1;
                else m[i] = 1'b0;
            end
        end
        return m;
    endfunction

    // Tag a request by the rule that decides its result.
    function automatic string tag_for(logic [7:0] d, logic lg, logic [1:0] sh, logic [2:0] md);
        if (md == 3'd1) return "R10";
        if (md == 3'd6) return "R11";
        if (sh == 2'd1) return "R3";
        if (sh == 2'd2) return "R4";
        if (sh == 2'd3) return "R5";
        if (!lg) return "R6";
        if (d[7:4] == 4'h3) return "R8";
        if (d == 8'h00 || d == 8'hFF) return "R9";
        return "R7";
    endfunction

    logic         e_valid = 1'b0;
    logic [N-1:0] e_mask  = '0;
    logic [7:0]   e_vec   = '0;
    logic [2:0]   e_mode  = '0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: advance on each edge, compare a quarter period later.
    always @(posedge clk) begin
        string tg;
        if (!rst_n) begin
            e_valid = 1'b0; e_mask = '0; e_vec = '0; e_mode = '0;
            tg = "R1";
        end else begin
            e_valid = req_valid;
            if (req_valid) begin
                e_mask = ref_mask(dest, logical_mode, shorthand, dlv_mode, int'(self_idx));
                e_vec  = vector;
                e_mode = dlv_mode;
                tg = cur_tag;
            end else begin
                tg = "R2";
            end
        end
        #(CLK_P/4);
        chk(tg, "valid", 32'(mask_valid), 32'(e_valid));
        chk(tg, "mask",  32'(target_mask), 32'(e_mask));
        chk(tg, "vector", 32'(out_vector), 32'(e_vec));
        chk(tg, "mode",  32'(out_mode), 32'(e_mode));
    end

    task automatic send(logic [7:0] d, logic lg, logic [1:0] sh, logic [2:0] md,
                        logic [7:0] v, int me);
        @(negedge clk);
        dest = d; logical_mode = lg; shorthand = sh; dlv_mode = md;
        vector = v; self_idx = IDX_W'(me); req_valid = 1'b1;
        cur_tag = tag_for(d, lg, sh, md);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: identifier match, broadcast, no match
        send(8'h07, 1'b0, 2'd0, 3'd0, 8'h41, 0);
        send(8'hFF, 1'b0, 2'd0, 3'd0, 8'h42, 0);
        send(8'h99, 1'b0, 2'd0, 3'd0, 8'h43, 0);
        // R7: flat logical
        send(8'h83, 1'b1, 2'd0, 3'd0, 8'h44, 0);
        // R8: cluster logical, plus mismatch of upper nibble
        send(8'h33, 1'b1, 2'd0, 3'd0, 8'h45, 0);
        send(8'h21, 1'b1, 2'd0, 3'd4, 8'h46, 0);
        // R9: unit 6 (model 5) must stay clear even for all-ones
        send(8'hFF, 1'b1, 2'd0, 3'd0, 8'h47, 0);
        // R3 / R4 / R5 shorthands
        send(8'h07, 1'b0, 2'd1, 3'd0, 8'h48, 5);
        send(8'h99, 1'b0, 2'd2, 3'd0, 8'h49, 2);
        send(8'h99, 1'b0, 2'd3, 3'd0, 8'h4A, 0);
        send(8'h99, 1'b0, 2'd3, 3'd0, 8'h4B, 7);
        // R10: lowest priority, including empty and all-but-sender
        send(8'hFF, 1'b0, 2'd0, 3'd1, 8'h4C, 0);
        send(8'h0C, 1'b1, 2'd0, 3'd1, 8'h4D, 0);
        send(8'h99, 1'b0, 2'd0, 3'd1, 8'h4E, 0);
        send(8'h00, 1'b0, 2'd3, 3'd1, 8'h4F, 0);
        // R11: startup keeps full mask and vector
        send(8'hFF, 1'b0, 2'd0, 3'd6, 8'h9A, 0);
        send(8'h0F, 1'b1, 2'd3, 3'd6, 8'h9B, 1);
        // R2: idle cycles hold the outputs
        repeat (4) @(negedge clk);
        // R2: back-to-back requests
        @(negedge clk);
        dest = 8'h20; logical_mode = 1'b0; shorthand = 2'd0; dlv_mode = 3'd0;
        vector = 8'h11; self_idx = '0; req_valid = 1'b1; cur_tag = "R2";
        @(negedge clk);
        dest = 8'h21; vector = 8'h12;
        @(negedge clk);
        req_valid = 1'b0;
        // Mixed scenarios
        for (int k = 0; k < N_RAND; k++) begin
            logic [7:0] d;
            int sel = $urandom_range(0, 3);
            d = (sel == 0) ? cfg_id[$urandom_range(0, N-1)] :
                (sel == 1) ? 8'hFF : 8'($urandom);
            send(d, 1'($urandom), 2'($urandom), 3'($urandom), 8'($urandom),
                 $urandom_range(0, N-1));
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        // R1: reset clears everything
        @(negedge clk);
        req_valid = 1'b1; cur_tag = "R1";
        rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule